// File: doc/BRIEF.md
# Event Timer Global Control

This block is the shared control section of a multi-channel event timer. It owns a constant capability word, a general configuration word whose bit 0 runs or halts the timer, a per-channel interrupt status word, and the 64-bit main counter. Software reaches all four through one small register port. The channels reach the block through status-set inputs and through pulse outputs that tell them to clear, re-raise or drop their interrupts.

The main counter counts up by one on each clock while the timer runs and holds its value while the timer is halted. Software may load the counter only while the timer is halted. When the timer starts, every channel that has a pending status and has its interrupt enabled is told to raise its line again. When the timer halts, all channels are told to disarm. Pending status bits stay set, and each channel then lowers its own line.

Registers are selected by `reg_addr_i`: 0 is capability, 1 is configuration, 2 is interrupt status and 3 is the main counter. Read data is combinational from the address.

Top module: `et_global_ctrl`

## Requirements
- R1: The capability register (address 0) always reads `CAP_VALUE`. Writes to it change no register.
- R2: A configuration write (address 1) updates only the bits set in `CFG_WMASK` (default 0x3). All other bits keep their old value and read 0 after reset.
- R3: Writing the status register (address 2) clears each bit N where the written bit N is 1 and status bit N is currently set. Bits written 0 are kept. In the cycle after the write, `ch_status_clr_o` pulses for exactly the bits that were cleared.
- R4: A high `ch_status_set_i[N]` sets status bit N on the next edge. If a set and a clear hit the same bit in the same cycle, the set wins and no clear pulse is given for that bit.
- R5: While running, the main counter increases by exactly 1 on every clock and wraps from 2^64-1 to 0.
- R6: Clearing configuration bit 0 freezes the counter. Setting it again resumes counting from the frozen value. The edge on which the enable bit is set does not increment the counter. The edge on which it is cleared does.
- R7: A counter write (address 3) loads the written value while the timer is halted. While the timer runs, the write is ignored and counting continues.
- R8: On the edge where configuration bit 0 goes 0 to 1, `ch_reassert_o` pulses for one cycle with status AND `ch_int_en_i` (both as they were at the write).
- R9: On the edge where configuration bit 0 goes 1 to 0, `ch_disarm_o` pulses for one cycle, and the status register is left unchanged.
- R10: `tmr_enable_o` equals configuration bit 0, and `cnt_o` always shows the main counter value.
- R11: Reset clears the configuration, the status, the counter and all pulse outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 cap, 1 cfg, 2 status, 3 counter |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data for the selected register |
| ch_status_set_i | input | N_CH | Per-channel status set request |
| ch_int_en_i | input | N_CH | Per-channel interrupt enable, used at timer start |
| ch_status_clr_o | output | N_CH | One-cycle pulse per cleared status bit |
| ch_reassert_o | output | N_CH | One-cycle pulse telling channels to raise their line again |
| ch_disarm_o | output | 1 | One-cycle pulse telling all channels to disarm |
| tmr_enable_o | output | 1 | Timer running |
| cnt_o | output | 64 | Live main counter value |

## Verification
The status register is swept over every pair of pending pattern and write pattern for four channels. A design that cleared bits that were not set, or cleared on a written zero, would show wrong clear pulses or wrong read-back. A set and a clear on the same bit in the same cycle checks that a new event is not lost. The counter is checked around start and halt edges, where an extra or missing increment would show up as an off-by-one. It is also loaded just below 2^64 to prove the wrap. A load while running must leave counting untouched, and starting the timer must re-raise only the channels that are both pending and enabled.

// File: rtl/et_pkg.sv
package et_pkg;
  typedef enum logic [1:0] {
    ADDR_CAP = 2'd0,
    ADDR_CFG = 2'd1,
    ADDR_STS = 2'd2,
    ADDR_CNT = 2'd3
  } et_reg_e;

  localparam int CFG_EN_BIT = 0;
  localparam int CNT_W      = 64;
endpackage

// File: rtl/et_cfg_reg.sv
module et_cfg_reg #(
  parameter logic [63:0] WMASK = 64'h3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [63:0] wdata_i,
  output logic [63:0] cfg_o,
  output logic        en_rise_o,
  output logic        en_fall_o
);
  import et_pkg::*;

  logic [63:0] cfg_q, cfg_d;

  assign cfg_d = (cfg_q & ~WMASK) | (wdata_i & WMASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (wr_i) cfg_q <= cfg_d;
  end

  assign cfg_o     = cfg_q;
  assign en_rise_o = wr_i &  cfg_d[CFG_EN_BIT] & ~cfg_q[CFG_EN_BIT];
  assign en_fall_o = wr_i & ~cfg_d[CFG_EN_BIT] &  cfg_q[CFG_EN_BIT];
endmodule

// File: rtl/et_main_counter.sv
module et_main_counter #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (run_i)  cnt_q <= cnt_q + {{(W-1){1'b0}}, 1'b1};
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/et_status_bank.sv
module et_status_bank #(
  parameter int N_CH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] set_i,
  input  logic            clr_wr_i,
  input  logic [N_CH-1:0] clr_mask_i,
  output logic [N_CH-1:0] sts_o,
  output logic [N_CH-1:0] cleared_o
);
  logic [N_CH-1:0] sts_q;

  for (genvar g = 0; g < N_CH; g++) begin : g_bit
    logic hit;
    assign hit = clr_wr_i & clr_mask_i[g] & sts_q[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       sts_q[g] <= 1'b0;
      else if (set_i[g]) sts_q[g] <= 1'b1;
      else if (hit)      sts_q[g] <= 1'b0;
    end
    // set has priority: no clear reported if the bit stays
    assign cleared_o[g] = hit & ~set_i[g];
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/et_global_ctrl.sv
module et_global_ctrl #(
  parameter int          N_CH      = 4,
  parameter logic [63:0] CAP_VALUE = 64'h05F5_E100_0000_8301,
  parameter logic [63:0] CFG_WMASK = 64'h0000_0000_0000_0003
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [1:0]      reg_addr_i,
  input  logic [63:0]     reg_wdata_i,
  output logic [63:0]     reg_rdata_o,
  input  logic [N_CH-1:0] ch_status_set_i,
  input  logic [N_CH-1:0] ch_int_en_i,
  output logic [N_CH-1:0] ch_status_clr_o,
  output logic [N_CH-1:0] ch_reassert_o,
  output logic            ch_disarm_o,
  output logic            tmr_enable_o,
  output logic [63:0]     cnt_o
);
  import et_pkg::*;

  logic            wr_cfg, wr_sts, wr_cnt;
  logic [63:0]     cfg_q, cnt_q;
  logic            en_rise, en_fall, run;
  logic [N_CH-1:0] status_q, cleared;
  logic [N_CH-1:0] clr_q, reassert_q;
  logic            disarm_q;

  assign wr_cfg = reg_we_i && (reg_addr_i == ADDR_CFG);
  assign wr_sts = reg_we_i && (reg_addr_i == ADDR_STS);
  assign wr_cnt = reg_we_i && (reg_addr_i == ADDR_CNT);

  et_cfg_reg #(.WMASK(CFG_WMASK)) u_cfg (
    .clk_i, .rst_ni,
    .wr_i      (wr_cfg),
    .wdata_i   (reg_wdata_i),
    .cfg_o     (cfg_q),
    .en_rise_o (en_rise),
    .en_fall_o (en_fall)
  );

  assign run = cfg_q[CFG_EN_BIT];

  et_main_counter #(.W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .run_i      (run),
    .load_i     (wr_cnt & ~run),  // loads while running are dropped
    .load_val_i (reg_wdata_i),
    .cnt_o      (cnt_q)
  );

  et_status_bank #(.N_CH(N_CH)) u_sts (
    .clk_i, .rst_ni,
    .set_i      (ch_status_set_i),
    .clr_wr_i   (wr_sts),
    .clr_mask_i (reg_wdata_i[N_CH-1:0]),
    .sts_o      (status_q),
    .cleared_o  (cleared)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_q      <= '0;
      reassert_q <= '0;
      disarm_q   <= 1'b0;
    end else begin
      clr_q      <= cleared;
      reassert_q <= en_rise ? (status_q & ch_int_en_i) : '0;
      disarm_q   <= en_fall;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CAP: reg_rdata_o = CAP_VALUE;
      ADDR_CFG: reg_rdata_o = cfg_q;
      ADDR_STS: reg_rdata_o = 64'(status_q);
      default:  reg_rdata_o = cnt_q;
    endcase
  end

  assign ch_status_clr_o = clr_q;
  assign ch_reassert_o   = reassert_q;
  assign ch_disarm_o     = disarm_q;
  assign tmr_enable_o    = run;
  assign cnt_o           = cnt_q;
endmodule

// File: rtl/et_global_ctrl_chk.sv
module et_global_ctrl_chk #(
  parameter int          N_CH      = 4,
  parameter logic [63:0] CFG_WMASK = 64'h3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            reg_we_i,
  input logic [1:0]      reg_addr_i,
  input logic [63:0]     cfg_q,
  input logic [N_CH-1:0] status_q,
  input logic [N_CH-1:0] ch_status_set_i,
  input logic [N_CH-1:0] ch_status_clr_o,
  input logic [N_CH-1:0] ch_reassert_o,
  input logic            ch_disarm_o,
  input logic            tmr_enable_o,
  input logic [63:0]     cnt_o
);
  a_r2_unmasked_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q & ~CFG_WMASK) == 64'd0);

  a_r3_clr_only_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ch_status_clr_o) |-> ((ch_status_clr_o & ~$past(status_q)) == '0 && (ch_status_clr_o & status_q) == '0));

  a_r4_set_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ch_status_set_i) |=> ((status_q & $past(ch_status_set_i)) == $past(ch_status_set_i)));

  a_r5_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_enable_o |=> (cnt_o == $past(cnt_o) + 64'd1));

  a_r6_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tmr_enable_o && !(reg_we_i && reg_addr_i == 2'd3)) |=> $stable(cnt_o));

  a_r8_reassert_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ch_reassert_o) |-> $rose(tmr_enable_o));

  a_r9_disarm_on_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tmr_enable_o) |-> ch_disarm_o);

  a_r9_disarm_only_on_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_disarm_o |-> $fell(tmr_enable_o));
endmodule

bind et_global_ctrl et_global_ctrl_chk #(.N_CH(N_CH), .CFG_WMASK(CFG_WMASK)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .reg_we_i        (reg_we_i),
  .reg_addr_i      (reg_addr_i),
  .cfg_q           (cfg_q),
  .status_q        (status_q),
  .ch_status_set_i (ch_status_set_i),
  .ch_status_clr_o (ch_status_clr_o),
  .ch_reassert_o   (ch_reassert_o),
  .ch_disarm_o     (ch_disarm_o),
  .tmr_enable_o    (tmr_enable_o),
  .cnt_o           (cnt_o)
);

// File: tb/et_global_ctrl_bench.sv
`timescale 1ns/1ps
module et_global_ctrl_bench;
  localparam int          N   = 4;
  localparam logic [63:0] CAP = 64'h05F5_E100_0000_8301;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            we = 1'b0;
  logic [1:0]      addr = 2'd0;
  logic [63:0]     wdata = '0;
  logic [63:0]     rdata;
  logic [N-1:0]    sset = '0;
  logic [N-1:0]    inten = '0;
  logic [N-1:0]    clr, reas;
  logic            disarm, en;
  logic [63:0]     cnt;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  et_global_ctrl u_et_global_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ch_status_set_i(sset),
    .ch_int_en_i(inten), .ch_status_clr_o(clr), .ch_reassert_o(reas),
    .ch_disarm_o(disarm), .tmr_enable_o(en), .cnt_o(cnt)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [63:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse_set(input logic [N-1:0] s);
    sset = s;
    @(posedge clk); @(negedge clk);
    sset = '0;
  endtask

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] v, c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    rd(2'd1, v); chk("R11 cfg", v, 64'd0);
    rd(2'd2, v); chk("R11 status", v, 64'd0);
    rd(2'd3, v); chk("R11 counter", v, 64'd0);
    chk("R11 pulses", {clr, reas, disarm, en}, '0);

    // R1 capability read-only
    rd(2'd0, v); chk("R1 cap read", v, CAP);
    wr(2'd0, '1);
    rd(2'd0, v); chk("R1 cap after write", v, CAP);
    rd(2'd1, v); chk("R1 cfg untouched", v, 64'd0);
    rd(2'd3, v); chk("R1 cnt untouched", v, 64'd0);

    // R2 / R10 write mask
    wr(2'd1, '1);
    rd(2'd1, v); chk("R2 masked cfg", v, 64'h3);
    chk("R10 enable out", {63'd0, en}, 64'd1);
    wr(2'd1, 64'hFFFF_FFFF_FFFF_FFFC);
    rd(2'd1, v); chk("R2 masked clear", v, 64'd0);
    chk("R10 enable low", {63'd0, en}, 64'd0);
    wr(2'd3, 64'd0);

    // R3 exhaustive W1C sweep
    for (int s = 0; s < 16; s++) begin
      for (int w = 0; w < 16; w++) begin
        if (s != 0) pulse_set(N'(s));
        wr(2'd2, 64'(w));
        chk("R3 clear pulse", 64'(clr), 64'(s & w));
        rd(2'd2, v); chk("R3 status left", v, 64'(s & ~w & 4'hF));
        wr(2'd2, 64'hF);
      end
    end

    // R4 set beats clear in same cycle
    pulse_set(4'b0010);
    sset = 4'b0010; we = 1'b1; addr = 2'd2; wdata = 64'h2;
    @(posedge clk); @(negedge clk);
    sset = '0; we = 1'b0; wdata = '0;
    chk("R4 no clear pulse", 64'(clr), 64'd0);
    rd(2'd2, v); chk("R4 set wins", v, 64'h2);
    wr(2'd2, 64'hF);

    // R5 R6 R7 counting, freeze, resume
    wr(2'd3, 64'd100);
    rd(2'd3, v); chk("R7 load halted", v, 64'd100);
    wr(2'd1, 64'd1);
    rd(2'd3, v); chk("R6 no step on start edge", v, 64'd100);
    repeat (5) @(negedge clk);
    rd(2'd3, v); chk("R5 counts", v, 64'd105);
    chk("R10 cnt_o live", cnt, 64'd105);
    wr(2'd3, 64'd7);
    rd(2'd3, v); chk("R7 write while running ignored", v, 64'd106);
    wr(2'd1, 64'd0);
    rd(2'd3, v); chk("R6 step on halt edge", v, 64'd107);
    repeat (4) @(negedge clk);
    rd(2'd3, v); chk("R6 frozen", v, 64'd107);
    wr(2'd1, 64'd1);
    repeat (3) @(negedge clk);
    rd(2'd3, v); chk("R6 resume from frozen", v, 64'd110);
    wr(2'd1, 64'd0);

    // R5 wrap
    wr(2'd3, 64'hFFFF_FFFF_FFFF_FFFE);
    wr(2'd1, 64'd1);
    rd(2'd3, c0); chk("R5 wrap start", c0, 64'hFFFF_FFFF_FFFF_FFFE);
    @(negedge clk); rd(2'd3, v); chk("R5 at max", v, '1);
    @(negedge clk); rd(2'd3, v); chk("R5 wrapped", v, 64'd0);
    wr(2'd1, 64'd0);
    chk("R9 disarm pulse", {63'd0, disarm}, 64'd1);
    @(negedge clk);
    chk("R9 disarm one cycle", {63'd0, disarm}, 64'd0);

    // R8 reassert on start, R9 status kept on halt
    pulse_set(4'b1011);
    inten = 4'b0110;
    wr(2'd1, 64'd1);
    chk("R8 reassert mask", 64'(reas), 64'b0010);
    @(negedge clk);
    chk("R8 reassert one cycle", 64'(reas), 64'd0);
    inten = 4'b1111;
    wr(2'd1, 64'd3);
    chk("R8 no reassert without rising edge", 64'(reas), 64'd0);
    wr(2'd1, 64'd0);
    chk("R9 disarm on halt", {63'd0, disarm}, 64'd1);
    rd(2'd2, v); chk("R9 status kept", v, 64'b1011);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule